// File: doc/BRIEF.md
# Sequential Restoring Unsigned Divider

This block divides one unsigned integer by another, producing one quotient bit on each clock cycle. A start strobe captures the dividend and the divisor while the block is idle. The partial remainder, one bit wider than the operands, and the quotient register are treated as a single register that shifts left on each step. A trial subtraction of the divisor follows each shift. When the trial result is negative, the divisor is added back to restore the remainder.

A division by zero is detected when the request is accepted. It is not iterated. A zero divisor with a zero dividend raises an indeterminate flag. A zero divisor with any other dividend raises an infinite flag. In both cases the block completes in one cycle and returns zero results. The operand width is set by the parameter `W`, which defaults to 4.

Top module: `divRestoring`

## Requirements
- R1: A synchronous active-high reset clears busy, done, both error flags, the quotient and the remainder to zero.
- R2: A start strobe is accepted only on a clock edge where busy is low. A strobe seen while busy is ignored: the running division keeps its captured operands and its completion timing.
- R3: For a nonzero divisor, busy is high from the edge after acceptance for W cycles. At the W-th edge after the accepting edge, busy falls and done rises in the same cycle. Busy and done are never high together.
- R4: When done is high after a nonzero-divisor division, the quotient equals floor(dividend/divisor) and the remainder (W+1 bits) equals dividend mod divisor. Therefore dividend = quotient*divisor + remainder, and remainder < divisor.
- R5: After every iteration step, the restored partial remainder is strictly smaller than the captured divisor.
- R6: A request with a zero dividend and a zero divisor sets errIndeterminate and completes with done on the edge after acceptance. Busy stays low, and the quotient and remainder read zero.
- R7: A request with a nonzero dividend and a zero divisor sets errInfinite and clears errIndeterminate. It completes with done on the edge after acceptance. Busy stays low, and the quotient and remainder read zero.
- R8: The error flags, the quotient and the remainder hold their values until the next start is accepted. Accepting a start with a nonzero divisor clears both error flags.
- R9: Done is high for exactly one cycle per completed request, and the two error flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| startReq | input | 1 | Start strobe, honoured only while idle |
| dividendIn | input | W | Unsigned dividend, captured on acceptance |
| divisorIn | input | W | Unsigned divisor, captured on acceptance |
| quotient | output | W | Quotient register |
| remainder | output | W+1 | Partial or final remainder register |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | High while iterations are running |
| errIndeterminate | output | 1 | Last request was 0/0 |
| errInfinite | output | 1 | Last request was x/0 with x nonzero |

## Verification
The bench builds the block with the default W = 4. At this width all 256 operand pairs can be exercised exhaustively, including both divide-by-zero classes and the extremes 15/1 and 15/15, within a short run. The bench also checks the exact completion cycle of every request. Seeded random start strobes are raised during running divisions to show that they are ignored.

// File: rtl/divPkg.sv
package divPkg;
  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic load;      // capture operands for an iterative division
    logic zeroLoad;  // divide-by-zero request: clear results
    logic step;      // perform one shift / trial / restore iteration
  } divCtrl_t;
endpackage

// File: rtl/divCtrl.sv
module divCtrl
  import divPkg::*;
#(
  parameter int W = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     startReq,
  input  logic     dividendZero,
  input  logic     divisorZero,
  output divCtrl_t ctrl,
  output logic     busy,
  output logic     done,
  output logic     errIndeterminate,
  output logic     errInfinite
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

  logic [CW-1:0] stepCnt;
  logic          accept;

  assign accept        = startReq && !busy;
  assign ctrl.load     = accept && !divisorZero;
  assign ctrl.zeroLoad = accept && divisorZero;
  assign ctrl.step     = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy             <= 1'b0;
      done             <= 1'b0;
      stepCnt          <= '0;
      errIndeterminate <= 1'b0;
      errInfinite      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        errIndeterminate <= divisorZero && dividendZero;
        errInfinite      <= divisorZero && !dividendZero;
        if (divisorZero) begin
          done <= 1'b1;
        end else begin
          busy    <= 1'b1;
          stepCnt <= '0;
        end
      end else if (busy) begin
        if (stepCnt == LAST_STEP) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          stepCnt <= stepCnt + 1'b1;
        end
      end
    end
  end

  assert_busy_done_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  assert_done_single_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({errIndeterminate, errInfinite}));
  assert_start_ignored_when_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && startReq) |=> (busy || done));
  assert_zero_finishes_next_R6: assert property (@(posedge clk) disable iff (rst)
    (startReq && !busy && divisorZero) |=> (done && !busy));
endmodule

// File: rtl/divPath.sv
module divPath
  import divPkg::*;
#(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  divCtrl_t       ctrl,
  input  logic [W-1:0]   dividendIn,
  input  logic [W-1:0]   divisorIn,
  output logic [W-1:0]   quotient,
  output logic [W:0]     remainder
);
  logic [W-1:0] quoReg;
  logic [W:0]   remReg;
  logic [W-1:0] divReg;
  logic [W:0]   divWide;
  logic [W:0]   shifted;
  logic [W:0]   trial;
  logic [W:0]   restored;
  logic         nonNeg;
  logic [W:0]   nextRem;
  logic [W-1:0] nextQuo;

  // One iteration: shift pair left, trial subtract, restore when negative
  always_comb begin
    divWide  = {1'b0, divReg};
    shifted  = {remReg[W-1:0], quoReg[W-1]};
    trial    = shifted - divWide;
    nonNeg   = !trial[W];
    restored = trial + divWide;
    nextRem  = nonNeg ? trial : restored;
    nextQuo  = {quoReg[W-2:0], nonNeg};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quoReg <= '0;
      remReg <= '0;
      divReg <= '0;
    end else if (ctrl.load) begin
      quoReg <= dividendIn;
      remReg <= '0;
      divReg <= divisorIn;
    end else if (ctrl.zeroLoad) begin
      quoReg <= '0;
      remReg <= '0;
      divReg <= '0;
    end else if (ctrl.step) begin
      quoReg <= nextQuo;
      remReg <= nextRem;
    end
  end

  assign quotient  = quoReg;
  assign remainder = remReg;

  assert_rem_below_divisor_R5: assert property (@(posedge clk) disable iff (rst)
    ctrl.step |=> (remainder < {1'b0, divReg}));
  assert_divisor_held_R2: assert property (@(posedge clk) disable iff (rst)
    ctrl.step |=> $stable(divReg));
endmodule

// File: rtl/divRestoring.sv
module divRestoring
  import divPkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         startReq,
  input  logic [W-1:0] dividendIn,
  input  logic [W-1:0] divisorIn,
  output logic [W-1:0] quotient,
  output logic [W:0]   remainder,
  output logic         done,
  output logic         busy,
  output logic         errIndeterminate,
  output logic         errInfinite
);
  divCtrl_t ctrl;

  divCtrl #(.W(W)) ctrl_i (
    .clk(clk), .rst(rst), .startReq(startReq),
    .dividendZero(dividendIn == '0), .divisorZero(divisorIn == '0),
    .ctrl(ctrl), .busy(busy), .done(done),
    .errIndeterminate(errIndeterminate), .errInfinite(errInfinite)
  );

  divPath #(.W(W)) path_i (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .dividendIn(dividendIn), .divisorIn(divisorIn),
    .quotient(quotient), .remainder(remainder)
  );

  assert_results_zero_on_error_R7: assert property (@(posedge clk) disable iff (rst)
    (done && (errInfinite || errIndeterminate)) |-> (quotient == '0 && remainder == '0));
endmodule

// File: tb/divRestoring_tb_top.sv
module divRestoring_tb_top;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         startReq = 1'b0;
  logic [W-1:0] dividendIn = '0;
  logic [W-1:0] divisorIn = '0;
  logic [W-1:0] quotient;
  logic [W:0]   remainder;
  logic         done, busy, errIndeterminate, errInfinite;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  divRestoring #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .startReq(startReq),
    .dividendIn(dividendIn), .divisorIn(divisorIn),
    .quotient(quotient), .remainder(remainder),
    .done(done), .busy(busy),
    .errIndeterminate(errIndeterminate), .errInfinite(errInfinite)
  );

  function automatic int expQuo(int a, int b); return a / b; endfunction
  function automatic int expRem(int a, int b); return a % b; endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drives one request; optional stray start while busy with other operands
  task automatic runDiv(input int a, input int b, input bit stray);
    @(negedge clk);
    startReq   = 1'b1;
    dividendIn = W'(a);
    divisorIn  = W'(b);
    @(posedge clk);
    @(negedge clk);
    startReq = 1'b0;
    if (b == 0) begin
      check(done == 1'b1, "R6/R7 done", done, 1);
      check(busy == 1'b0, "R6/R7 busy", busy, 0);
      if (a == 0) begin
        check(errIndeterminate && !errInfinite, "R6 flags",
              {errIndeterminate, errInfinite}, 2);
      end else begin
        check(errInfinite && !errIndeterminate, "R7 flags",
              {errIndeterminate, errInfinite}, 1);
      end
      check(quotient == '0 && remainder == '0, "R6/R7 zero results",
            int'(quotient), 0);
    end else begin
      for (int k = 1; k <= W; k++) begin
        if (k < W) begin
          if (!(busy && !done)) check(1'b0, "R3 busy window", {busy, done}, 2);
          if (stray && k == 1) begin
            startReq   = 1'b1;
            dividendIn = W'(a ^ 'hF);
            divisorIn  = W'((b % 15) + 1);
          end
        end
        @(posedge clk);
        @(negedge clk);
        startReq = 1'b0;
      end
      check(done && !busy, "R3 done timing", {busy, done}, 1);
      check(!errIndeterminate && !errInfinite, "R8 flags cleared",
            {errIndeterminate, errInfinite}, 0);
      check(int'(quotient) == expQuo(a, b), stray ? "R2 R4 quotient" : "R4 quotient",
            int'(quotient), expQuo(a, b));
      check(int'(remainder) == expRem(a, b), stray ? "R2 R4 remainder" : "R4 remainder",
            int'(remainder), expRem(a, b));
    end
    @(negedge clk);
    check(done == 1'b0, "R9 done single pulse", done, 0);
  endtask

  initial begin
    int seedVal;
    int hq;
    int hr;
    seedVal = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    // R1 reset state, with a start held during reset
    startReq = 1'b1; divisorIn = 4'd3; dividendIn = 4'd9;
    @(negedge clk);
    check(!busy && !done && !errIndeterminate && !errInfinite, "R1 control reset",
          {busy, done, errIndeterminate, errInfinite}, 0);
    check(quotient == '0 && remainder == '0, "R1 result reset", int'(remainder), 0);
    startReq = 1'b0;
    rst = 1'b0;
    @(negedge clk);

    // Directed corners
    runDiv(0, 0, 0);
    // R8: flag and results hold while idle
    repeat (3) @(negedge clk);
    check(errIndeterminate && !errInfinite, "R8 flag holds",
          {errIndeterminate, errInfinite}, 2);
    runDiv(15, 0, 0);
    runDiv(15, 1, 0);
    runDiv(15, 15, 0);
    runDiv(0, 7, 0);
    runDiv(7, 9, 0);
    // R8: results hold until next accepted start
    hq = int'(quotient); hr = int'(remainder);
    repeat (4) @(negedge clk);
    check(int'(quotient) == hq && int'(remainder) == hr, "R8 results hold",
          int'(quotient), hq);

    // Exhaustive sweep (R4, R6, R7)
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        runDiv(a, b, 0);
      end
    end

    // Random requests with stray starts while busy (R2)
    for (int i = 0; i < 200; i++) begin
      int ra;
      int rb;
      ra = int'($urandom_range(15, 0));
      rb = int'($urandom_range(15, 1));
      runDiv(ra, rb, ($urandom_range(1, 0) == 1));
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule